// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one memory-to-memory DMA channel driven by a small register window. Software loads the address of a first descriptor into a pointer register and sets a run bit. The channel then reads the descriptor from memory through a word-read port. It copies the requested number of bytes as whole 32-bit words from the source address to the target address, using the read port and a word-write port. It then follows the descriptor's link to the next descriptor, until a link carries the stop marker or software clears run.

A descriptor is eight 32-bit words on a 32-byte boundary. The words at byte offsets 0x00, 0x04, 0x08 and 0x0C hold the link low word, the source low word, the target low word and the command word. The words at 0x10, 0x14 and 0x18 hold the link, source and target high words, and 0x1C is unused. In long-address mode all eight words are fetched, and the high words form bits 63:32 of each address. In short mode only the first four words are fetched, and every address has zero upper bits. A link that points back at an earlier descriptor makes a cyclic transfer that runs until software stops it. An interrupt-enable flag in the command word raises a sticky interrupt when that descriptor finishes.

Top module: `dmac_chan`

## Requirements
- R1: After reset the control register reads 0, `irq` is low, and neither `rd_req` nor `wr_req` is asserted.
- R2: Setting the run bit (control bit 0) makes the channel read descriptor words at pointer, pointer+4, … in ascending order. It reads 4 words in short mode and 8 words when the long-address bit (control bit 1) is set.
- R3: The command word's bits 12:0 give a byte length. The channel copies floor(length/4) words in ascending address order, a read from the source followed by a write of that word to the target. A length below 4 completes with no copy access.
- R4: In long mode, descriptor words 4, 5 and 6 supply bits 63:32 of the link, source and target addresses. In short mode those bits are zero and words 4 to 7 are not fetched.
- R5: When a descriptor completes and bit 0 of its link low word is 0, the next fetch starts at the link address with its low 5 bits cleared.
- R6: When bit 0 of the link low word is 1, the channel clears run on completion, goes idle and makes no further memory access.
- R7: Command bit 31 set makes completion of that descriptor set the interrupt status (register 0x1C bit 0), which drives `irq`. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: A chain whose link points back to itself keeps running and raises the interrupt on each pass, with run still set.
- R9: Writes to the pointer registers (0x04 low, 0x08 high) while run is set are ignored. The register keeps the descriptor address in use.
- R10: Clearing run stops the channel once any pending bus handshake completes, and no new request is issued after that.
- R11: The current source (0x0C low, 0x10 high) and target (0x14 low, 0x18 high) registers are readable. Each advances by 4 per copied word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| rd_req | output | 1 | Memory read request, held until `rd_ack` |
| rd_addr | output | 64 | Memory read byte address |
| rd_ack | input | 1 | Read acknowledge, `rd_data` valid with it |
| rd_data | input | 32 | Memory read data |
| wr_req | output | 1 | Memory write request, held until `wr_ack` |
| wr_addr | output | 64 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Write acknowledge |
| irq | output | 1 | End-of-descriptor interrupt |

## Verification
A register write takes effect at the next clock edge. Register reads are combinational, so the bench sets the offset at a falling edge and samples shortly after it. Each memory access lasts two cycles with the bench's acknowledge. A descriptor therefore finishes a bounded number of cycles after run is set, and the bench waits for completion by polling the run bit rather than counting fixed delays. Stop and "no effect" checks wait a further ten cycles, then compare the access counters, the status register or the bus request lines against values captured before that interval.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  localparam int REG_AW     = 5;
  localparam int DESC_WORDS = 8;

  // register window offsets (bytes)
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_PTR_LO = 5'h04;
  localparam logic [REG_AW-1:0] OFS_PTR_HI = 5'h08;
  localparam logic [REG_AW-1:0] OFS_SRC_LO = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_SRC_HI = 5'h10;
  localparam logic [REG_AW-1:0] OFS_DST_LO = 5'h14;
  localparam logic [REG_AW-1:0] OFS_DST_HI = 5'h18;
  localparam logic [REG_AW-1:0] OFS_IRQ    = 5'h1C;

  // control bits
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_LONG = 1;

  // descriptor word slots (memory layout)
  localparam int W_LNK_LO = 0;
  localparam int W_SRC_LO = 1;
  localparam int W_DST_LO = 2;
  localparam int W_CMD    = 3;
  localparam int W_LNK_HI = 4;
  localparam int W_SRC_HI = 5;
  localparam int W_DST_HI = 6;
  localparam int W_RSVD   = 7;

  localparam int CMD_IE = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_RD,
    ST_WR,
    ST_DONE
  } eng_state_t;
endpackage

// File: rtl/dmac_csr.sv
`timescale 1ns/1ps
module dmac_csr
  import dmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              run,
  output logic              long_en,
  output logic              ptr_lo_we,
  output logic              ptr_hi_we,
  input  logic              run_clr,
  input  logic              end_evt,
  input  logic [2*DW-1:0]   ptr_cur,
  input  logic [2*DW-1:0]   src_cur,
  input  logic [2*DW-1:0]   dst_cur,
  output logic              irq
);
  logic run_q, run_d;
  logic long_q, long_d;
  logic irq_q, irq_d;
  logic ctrl_we, irq_we;

  assign ctrl_we   = reg_wen && (reg_addr == OFS_CTRL);
  assign irq_we    = reg_wen && (reg_addr == OFS_IRQ);
  // pointer loads are refused while the channel is enabled
  assign ptr_lo_we = reg_wen && (reg_addr == OFS_PTR_LO) && !run_q;
  assign ptr_hi_we = reg_wen && (reg_addr == OFS_PTR_HI) && !run_q;

  always_comb begin
    run_d  = run_q;
    long_d = long_q;
    irq_d  = irq_q;
    if (ctrl_we) begin
      run_d  = reg_wdata[CTRL_RUN];
      long_d = reg_wdata[CTRL_LONG];
    end
    if (run_clr) run_d = 1'b0;
    if (irq_we && reg_wdata[0]) irq_d = 1'b0;
    if (end_evt) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      long_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      long_q <= long_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTRL_RUN]  = run_q;
        reg_rdata[CTRL_LONG] = long_q;
      end
      OFS_PTR_LO: reg_rdata = ptr_cur[DW-1:0];
      OFS_PTR_HI: reg_rdata = ptr_cur[2*DW-1:DW];
      OFS_SRC_LO: reg_rdata = src_cur[DW-1:0];
      OFS_SRC_HI: reg_rdata = src_cur[2*DW-1:DW];
      OFS_DST_LO: reg_rdata = dst_cur[DW-1:0];
      OFS_DST_HI: reg_rdata = dst_cur[2*DW-1:DW];
      OFS_IRQ:    reg_rdata[0] = irq_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign run     = run_q;
  assign long_en = long_q;
  assign irq     = irq_q;
endmodule

// File: rtl/dmac_engine.sv
`timescale 1ns/1ps
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            long_en,
  input  logic            ptr_lo_we,
  input  logic            ptr_hi_we,
  input  logic [DW-1:0]   ptr_wdata,
  output logic            rd_req,
  output logic [2*DW-1:0] rd_addr,
  input  logic            rd_ack,
  input  logic [DW-1:0]   rd_data,
  output logic            wr_req,
  output logic [2*DW-1:0] wr_addr,
  output logic [DW-1:0]   wr_data,
  input  logic            wr_ack,
  output logic [2*DW-1:0] ptr_cur,
  output logic [2*DW-1:0] src_cur,
  output logic [2*DW-1:0] dst_cur,
  output logic            run_clr,
  output logic            end_evt
);
  localparam int AW    = 2 * DW;
  localparam int CW    = LEN_W - 2;
  localparam int WI_W  = $clog2(DESC_WORDS);
  localparam int ALIGN = $clog2(DESC_WORDS * DW / 8);
  localparam int STEP  = DW / 8;

  eng_state_t st_q, st_d;
  logic [WI_W-1:0] widx_q, widx_d, last_idx;
  logic [AW-1:0]   ptr_q, ptr_d, src_q, src_d, dst_q, dst_d, fetch_base;
  logic [CW-1:0]   rem_q, rem_d;
  logic [DW-1:0]   buf_q, buf_d;
  logic [DW-1:0]   dw_q [DESC_WORDS];
  logic            dw_we;
  logic [DW-1:0]   lnk_lo, src_lo, dst_lo, cmd, lnk_hi, src_hi, dst_hi;
  logic [CW-1:0]   cmd_words;
  logic            unused_bits;

  assign lnk_lo    = dw_q[W_LNK_LO];
  assign src_lo    = dw_q[W_SRC_LO];
  assign dst_lo    = dw_q[W_DST_LO];
  assign cmd       = dw_q[W_CMD];
  assign lnk_hi    = dw_q[W_LNK_HI];
  assign src_hi    = dw_q[W_SRC_HI];
  assign dst_hi    = dw_q[W_DST_HI];
  assign cmd_words = cmd[LEN_W-1:2];
  assign unused_bits = ^{dw_q[W_RSVD], cmd[CMD_IE-1:LEN_W], cmd[1:0], lnk_lo[ALIGN-1:1]};

  // short mode: the walk is half a descriptor and upper address bits read as zero
  assign last_idx   = long_en ? WI_W'(DESC_WORDS - 1) : WI_W'(DESC_WORDS / 2 - 1);
  assign fetch_base = long_en ? ptr_q : {{DW{1'b0}}, ptr_q[DW-1:0]};

  always_comb begin
    st_d    = st_q;
    widx_d  = widx_q;
    ptr_d   = ptr_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    buf_d   = buf_q;
    dw_we   = 1'b0;
    run_clr = 1'b0;
    end_evt = 1'b0;
    if (ptr_lo_we && st_q == ST_IDLE) ptr_d[DW-1:0]  = ptr_wdata;
    if (ptr_hi_we && st_q == ST_IDLE) ptr_d[AW-1:DW] = ptr_wdata;
    unique case (st_q)
      ST_IDLE: begin
        if (run) begin
          st_d   = ST_FETCH;
          widx_d = '0;
        end
      end
      ST_FETCH: begin
        if (rd_ack) begin
          dw_we = 1'b1;
          if (!run)                   st_d = ST_IDLE;
          else if (widx_q == last_idx) st_d = ST_SETUP;
          else                        widx_d = widx_q + WI_W'(1);
        end
      end
      ST_SETUP: begin
        src_d = {long_en ? src_hi : {DW{1'b0}}, src_lo};
        dst_d = {long_en ? dst_hi : {DW{1'b0}}, dst_lo};
        rem_d = cmd_words;
        if (!run)                 st_d = ST_IDLE;
        else if (cmd_words == '0) st_d = ST_DONE;
        else                      st_d = ST_RD;
      end
      ST_RD: begin
        if (rd_ack) begin
          buf_d = rd_data;
          st_d  = run ? ST_WR : ST_IDLE;
        end
      end
      ST_WR: begin
        if (wr_ack) begin
          src_d = src_q + AW'(STEP);
          dst_d = dst_q + AW'(STEP);
          rem_d = rem_q - CW'(1);
          if (!run)                  st_d = ST_IDLE;
          else if (rem_q == CW'(1))  st_d = ST_DONE;
          else                       st_d = ST_RD;
        end
      end
      ST_DONE: begin
        end_evt = cmd[CMD_IE];
        if (lnk_lo[0]) begin
          run_clr = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          ptr_d  = {long_en ? lnk_hi : {DW{1'b0}}, lnk_lo[DW-1:ALIGN], {ALIGN{1'b0}}};
          widx_d = '0;
          st_d   = run ? ST_FETCH : ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      widx_q <= '0;
      ptr_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      buf_q  <= '0;
    end else begin
      st_q   <= st_d;
      widx_q <= widx_d;
      ptr_q  <= ptr_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      rem_q  <= rem_d;
      buf_q  <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC_WORDS; i++) dw_q[i] <= '0;
    end else if (dw_we) begin
      dw_q[widx_q] <= rd_data;
    end
  end

  assign rd_req  = (st_q == ST_FETCH) || (st_q == ST_RD);
  assign rd_addr = (st_q == ST_FETCH) ? fetch_base + AW'({widx_q, 2'b00}) : src_q;
  assign wr_req  = (st_q == ST_WR);
  assign wr_addr = dst_q;
  assign wr_data = buf_q;
  assign ptr_cur = ptr_q;
  assign src_cur = src_q;
  assign dst_cur = dst_q;
endmodule

// File: rtl/dmac_chan.sv
`timescale 1ns/1ps
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              rd_req,
  output logic [2*DW-1:0]   rd_addr,
  input  logic              rd_ack,
  input  logic [DW-1:0]     rd_data,
  output logic              wr_req,
  output logic [2*DW-1:0]   wr_addr,
  output logic [DW-1:0]     wr_data,
  input  logic              wr_ack,
  output logic              irq
);
  logic            run_w, long_w, ptr_lo_we_w, ptr_hi_we_w, run_clr_w, end_evt_w;
  logic [2*DW-1:0] ptr_w, src_w, dst_w;

  dmac_csr #(.DW(DW)) csr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .run       (run_w),
    .long_en   (long_w),
    .ptr_lo_we (ptr_lo_we_w),
    .ptr_hi_we (ptr_hi_we_w),
    .run_clr   (run_clr_w),
    .end_evt   (end_evt_w),
    .ptr_cur   (ptr_w),
    .src_cur   (src_w),
    .dst_cur   (dst_w),
    .irq       (irq)
  );

  dmac_engine #(.DW(DW), .LEN_W(LEN_W)) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .long_en   (long_w),
    .ptr_lo_we (ptr_lo_we_w),
    .ptr_hi_we (ptr_hi_we_w),
    .ptr_wdata (reg_wdata),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .ptr_cur   (ptr_w),
    .src_cur   (src_w),
    .dst_cur   (dst_w),
    .run_clr   (run_clr_w),
    .end_evt   (end_evt_w)
  );
endmodule

// File: rtl/dmac_chan_chk.sv
`timescale 1ns/1ps
module dmac_chan_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            rd_ack,
  input logic [2*DW-1:0] rd_addr,
  input logic            wr_req,
  input logic            wr_ack,
  input logic [2*DW-1:0] wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            run,
  input logic            end_evt,
  input logic            irq
);
  // R3: a copy never reads and writes in the same cycle
  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // R2: an unanswered read keeps its request and address
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R3: an unanswered write keeps its request, address and data
  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R10: with run clear and nothing pending, no new request appears
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !rd_req && !wr_req) |=> (!rd_req && !wr_req));

  // R7: the interrupt only rises after a descriptor completion event
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(end_evt));
endmodule

bind dmac_chan dmac_chan_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_req  (rd_req),
  .rd_ack  (rd_ack),
  .rd_addr (rd_addr),
  .wr_req  (wr_req),
  .wr_ack  (wr_ack),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .run     (run_w),
  .end_evt (end_evt_w),
  .irq     (irq)
);

// File: tb/dmac_chan_tb_top.sv
`timescale 1ns/1ps
module dmac_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wen;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rd_req, rd_ack, wr_req, wr_ack, irq;
  logic [63:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  always #4 clk = ~clk;

  dmac_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .irq(irq)
  );

  logic [31:0] mem [1024];
  int          rd_cnt, wr_cnt;
  logic [31:0] wr_hi;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack <= 1'b0;
      wr_ack <= 1'b0;
    end else begin
      rd_ack <= rd_req && !rd_ack;
      if (rd_req && !rd_ack) begin
        rd_data <= mem[rd_addr[11:2]];
        rd_cnt  <= rd_cnt + 1;
      end
      wr_ack <= wr_req && !wr_ack;
      if (wr_req && !wr_ack) begin
        mem[wr_addr[11:2]] <= wr_data;
        wr_cnt <= wr_cnt + 1;
        wr_hi  <= wr_addr[63:32];
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] c;
    for (int i = 0; i < 400; i++) begin
      reg_rd(5'h00, c);
      if (c[0] == 1'b0) break;
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  typedef struct packed {
    logic        lng;
    logic [31:0] hi;
    logic [12:0] len;
    logic        ie;
    logic [7:0]  n_rd;
    logic [7:0]  n_wr;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 32'h0000_0005, 13'd12, 1'b1, 8'd7,  8'd3},
    '{1'b1, 32'h0000_0003, 13'd8,  1'b0, 8'd10, 8'd2},
    '{1'b0, 32'h0000_0009, 13'd3,  1'b1, 8'd4,  8'd0},
    '{1'b1, 32'h0000_0002, 13'd0,  1'b0, 8'd8,  8'd0},
    '{1'b0, 32'h0000_0007, 13'd16, 1'b0, 8'd8,  8'd4}
  };

  initial begin
    logic [31:0] r;
    int          c;
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    rd_cnt = 0; wr_cnt = 0; wr_hi = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_rd(5'h00, r); check("R1 ctrl", r, 0);
    check("R1 irq", irq, 0);
    check("R1 req", {rd_req, wr_req}, 0);

    // table walk: single descriptors with stop marker
    for (int t = 0; t < 5; t++) begin
      vec_t v;
      int   nw;
      v  = VECS[t];
      nw = int'(v.len) / 4;
      for (int k = 0; k < 16; k++) begin
        mem[32'h100 + k] = '0;
        mem[32'h80 + k]  = 32'hA000_0000 + t * 256 + k;
      end
      mem[0] = 32'h1; mem[1] = 32'h200; mem[2] = 32'h400;
      mem[3] = {v.ie, 18'b0, v.len};
      mem[4] = 32'h0; mem[5] = v.hi; mem[6] = v.hi; mem[7] = 32'h0;
      reg_wr(5'h04, 32'h0);
      reg_wr(5'h08, 32'h0);
      rd_cnt = 0; wr_cnt = 0;
      reg_wr(5'h00, {30'b0, v.lng, 1'b1});
      wait_stop();
      check("R2 fetch+copy reads", rd_cnt, v.n_rd);
      check("R3 writes", wr_cnt, v.n_wr);
      for (int k = 0; k < nw; k++)
        check("R3 data", mem[32'h100 + k], 32'hA000_0000 + t * 256 + k);
      check("R3 beyond length", mem[32'h100 + nw], 0);
      if (nw > 0) check("R4 upper target bits", wr_hi, v.lng ? v.hi : 32'h0);
      reg_rd(5'h0C, r); check("R11 src lo", r, 32'h200 + 4 * nw);
      reg_rd(5'h14, r); check("R11 dst lo", r, 32'h400 + 4 * nw);
      reg_rd(5'h10, r); check("R4 src hi", r, v.lng ? v.hi : 32'h0);
      c = rd_cnt;
      repeat (10) @(negedge clk);
      check("R6 no access after stop", rd_cnt, c);
      reg_rd(5'h00, r); check("R6 run cleared", r, {30'b0, v.lng, 1'b0});
      check("R7 irq", irq, v.ie);
      if (v.ie) begin
        reg_wr(5'h1C, 32'h0); check("R7 write0 keeps", irq, 1);
        reg_wr(5'h1C, 32'h1); check("R7 w1c", irq, 0);
      end
    end

    // R5: chained pair, link low bits 4:1 ignored
    for (int k = 0; k < 16; k++) mem[32'h80 + k] = 32'hB000_0000 + k;
    mem[32'h100] = 0; mem[32'h101] = 0; mem[32'h102] = 0; mem[32'h120] = 0;
    mem[0] = 32'h2E;  mem[1] = 32'h200; mem[2]  = 32'h400; mem[3]  = 32'd8;
    mem[8] = 32'h1;   mem[9] = 32'h210; mem[10] = 32'h480; mem[11] = 32'h8000_0004;
    reg_wr(5'h04, 32'h0);
    rd_cnt = 0; wr_cnt = 0;
    reg_wr(5'h00, 32'h1);
    wait_stop();
    check("R5 reads", rd_cnt, 11);
    check("R5 writes", wr_cnt, 3);
    check("R5 first copy", mem[32'h101], 32'hB000_0001);
    check("R5 second copy", mem[32'h120], 32'hB000_0004);
    check("R5 untouched", mem[32'h102], 0);
    check("R7 chain irq", irq, 1);
    reg_wr(5'h1C, 32'h1);

    // R8/R9/R10: self-linked cyclic descriptor
    mem[16] = 32'h40; mem[17] = 32'h200; mem[18] = 32'h500; mem[19] = 32'h8000_0004;
    mem[32'h140] = 0;
    reg_wr(5'h04, 32'h40);
    reg_wr(5'h00, 32'h1);
    wait_irq();
    check("R8 first pass irq", irq, 1);
    reg_wr(5'h1C, 32'h1);
    wait_irq();
    check("R8 second pass irq", irq, 1);
    reg_rd(5'h00, r); check("R8 still running", r[0], 1);
    check("R8 data", mem[32'h140], 32'hB000_0000);
    reg_wr(5'h04, 32'h300);
    reg_rd(5'h04, r); check("R9 ptr write ignored", r, 32'h40);
    reg_wr(5'h00, 32'h0);
    repeat (6) @(negedge clk);
    check("R10 no request", {rd_req, wr_req}, 0);
    c = rd_cnt;
    repeat (10) @(negedge clk);
    check("R10 reads stopped", rd_cnt, c);
    reg_rd(5'h00, r); check("R10 ctrl", r, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog all-requirements act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule